// File: doc/BRIEF.md
# One-shot minimum low-pulse detector

The block watches an asynchronous digital line that rests high and qualifies each low phase by its length in clock cycles. A fresh low phase starts a run-length counter. If the line stays low for at least a programmable number of cycles, a detect level rises and stays up for as long as the line remains low. A one-cycle event strobe and a sticky flag mark the qualification. Both are produced exactly once per low phase, however long that phase lasts. A low phase that ends early is dropped silently. Only a return to high, followed by a new low phase, re-arms the detector.

The raw line first passes through a flop synchroniser whose depth is a parameter. All timing below is counted in rising clock edges at the block's input. A typical setting is a threshold of 1000 cycles of a 20 MHz clock, which is a minimum low time of 50 µs. The flag is meant to feed an interrupt controller, and software clears it with a one-cycle strobe.

Top module: `lowpulse_qualifier`

## Requirements
- R1: After reset, detect_o, event_o and flag_o are all 0.
- R2: With effective threshold T, if sense_i is sampled low at T consecutive rising edges, then after the (T+1)th edge following the first low sample, detect_o is 1 and event_o is 1. Counting that first low sample as edge 0, this is edge T+1, and the delay comes from two synchroniser stages plus one state register.
- R3: A low phase sampled low at only T-1 edges yields no event_o, no flag_o and no detect_o.
- R4: event_o is high for exactly one cycle per qualifying low phase, even when the phase lasts many multiples of T.
- R5: detect_o stays 1 while the synchronised line is low. It drops after the second edge following the first edge that samples sense_i high again, which is edge L+2 for a phase sampled low at edges 0 to L-1.
- R6: After the line returns high, a new qualifying low phase produces a new event.
- R7: flag_o becomes 1 in the same cycle as event_o and holds until flag_clr_i is sampled high. When no event occurs in that cycle, the clear takes effect after that edge.
- R8: If flag_clr_i is high at the edge where an event registers, flag_o is still set (set wins over clear).
- R9: While sense_i stays high, event_o, detect_o and flag_o stay 0.
- R10: A threshold_i of 0 behaves as 1, so a single low sample qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sense_i | input | 1 | Raw asynchronous line, idles high |
| threshold_i | input | CNT_W | Minimum low length in cycles (0 treated as 1) |
| flag_clr_i | input | 1 | One-cycle strobe that clears the sticky flag |
| detect_o | output | 1 | High while a qualified low phase persists |
| event_o | output | 1 | One-cycle strobe on qualification |
| flag_o | output | 1 | Sticky qualification flag |

## Verification
Setting the sticky flag and clearing it are the two functions that can land on the same edge. The bench provokes this by holding flag_clr_i high across a whole qualifying low phase, so the clear is present exactly when the event registers. It then expects flag_o to be 1 in the event cycle and 0 one cycle later, because the clear is still asserted. A second collision, the line returning high on the very edge that would qualify, is covered by the threshold-minus-one and exact-threshold pulses.

// File: rtl/lpq_pkg.sv
package lpq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_MEASURE = 2'd1,
      ST_HELD    = 2'd2
   } lpq_state_e;
endpackage

// File: rtl/lpq_sync.sv
module lpq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          IDLE_LEVEL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic raw_i,
   output logic level_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lpq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= IDLE_LEVEL;
               else         chain_q[0] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[i] <= IDLE_LEVEL;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpq_runlen.sv
module lpq_runlen
   import lpq_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             level_i,
   input  logic [CNT_W-1:0] threshold_i,
   output logic             held_o,
   output logic             hit_o
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lpq_runlen: CNT_W must be at least 2");
      end
   endgenerate

   lpq_state_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] thr_eff, run_len;
   logic             hit_q, hit_d;

   assign thr_eff = (threshold_i == '0) ? ONE : threshold_i;
   assign run_len = (state_q == ST_IDLE) ? ONE
                  : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + ONE);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      hit_d   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!level_i) begin
               cnt_d = run_len;
               if (run_len >= thr_eff) begin
                  state_d = ST_HELD;
                  hit_d   = 1'b1;
               end else begin
                  state_d = ST_MEASURE;
               end
            end
         end
         ST_MEASURE: begin
            if (level_i) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end else begin
               cnt_d = run_len;
               if (run_len >= thr_eff) begin
                  state_d = ST_HELD;
                  hit_d   = 1'b1;
               end
            end
         end
         ST_HELD: begin
            if (level_i) begin
               state_d = ST_IDLE;
               cnt_d   = '0;
            end
         end
         default: begin
            state_d = ST_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hit_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         hit_q   <= hit_d;
      end
   end

   assign held_o = (state_q == ST_HELD);
   assign hit_o  = hit_q;
endmodule

// File: rtl/lowpulse_qualifier.sv
module lowpulse_qualifier #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sense_i,
   input  logic [CNT_W-1:0] threshold_i,
   input  logic             flag_clr_i,
   output logic             detect_o,
   output logic             event_o,
   output logic             flag_o
);
   logic sync_lvl;
   logic held, hit;
   logic flag_q;

   lpq_sync #(
      .STAGES    (SYNC_STAGES),
      .IDLE_LEVEL(1'b1)
   ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (sense_i),
      .level_o(sync_lvl)
   );

   lpq_runlen #(
      .CNT_W(CNT_W)
   ) runlen_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .level_i    (sync_lvl),
      .threshold_i(threshold_i),
      .held_o     (held),
      .hit_o      (hit)
   );

   // A qualification registered on the same edge outranks a clear request.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= hit_set_next() | (flag_q & ~flag_clr_i);
   end

   function automatic logic hit_set_next();
      return (runlen_i.state_d == lpq_pkg::ST_HELD) && (runlen_i.state_q != lpq_pkg::ST_HELD);
   endfunction

   assign detect_o = held;
   assign event_o  = hit;
   assign flag_o   = flag_q;
endmodule

// File: rtl/lpq_checker.sv
module lpq_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic lvl_i,
   input logic flag_clr_i,
   input logic detect_o,
   input logic event_o,
   input logic flag_o
);
   p_event_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_o |=> !event_o);
   p_event_detect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_o |-> detect_o);
   p_detect_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(detect_o) |-> event_o);
   p_detect_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (detect_o && !lvl_i) |=> detect_o);
   p_detect_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (detect_o && lvl_i) |=> !detect_o);
   p_flag_with_event_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_o |-> flag_o);
   p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !flag_clr_i) |=> flag_o);
   p_flag_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> event_o);
endmodule

bind lowpulse_qualifier lpq_checker chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .lvl_i     (sync_lvl),
   .flag_clr_i(flag_clr_i),
   .detect_o  (detect_o),
   .event_o   (event_o),
   .flag_o    (flag_o)
);

// File: tb/lowpulse_qualifier_tb_top.sv
`timescale 1ns/1ps
module lowpulse_qualifier_tb_top;
   localparam int CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_ni;
   logic             sense_i;
   logic [CNT_W-1:0] threshold_i;
   logic             flag_clr_i;
   logic             detect_o, event_o, flag_o;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // per-pulse observations
   int evt_cnt, evt_idx, det_cnt, det_first, det_fall, flag_at_evt, flag_after_evt;

   always #2 clk = ~clk;

   lowpulse_qualifier #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_ni),
      .sense_i    (sense_i),
      .threshold_i(threshold_i),
      .flag_clr_i (flag_clr_i),
      .detect_o   (detect_o),
      .event_o    (event_o),
      .flag_o     (flag_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Drives sense_i low for L rising edges (index 0..L-1), then high, and
   // observes outputs at the negedge after each edge index 0..L+8.
   task automatic pulse(input int L);
      evt_cnt = 0; evt_idx = -1; det_cnt = 0; det_first = -1; det_fall = -1;
      flag_at_evt = -1; flag_after_evt = -1;
      @(negedge clk);
      sense_i = 1'b0;
      for (int k = 0; k <= L + 8; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (evt_idx >= 0 && k == evt_idx + 1) flag_after_evt = int'(flag_o);
         if (event_o) begin
            evt_cnt++;
            if (evt_idx < 0) begin evt_idx = k; flag_at_evt = int'(flag_o); end
         end
         if (detect_o) begin
            det_cnt++;
            if (det_first < 0) det_first = k;
         end else if (det_first >= 0 && det_fall < 0) begin
            det_fall = k;
         end
         if (k == L - 1) sense_i = 1'b1;
      end
   endtask

   task automatic clear_flag();
      @(negedge clk); flag_clr_i = 1'b1;
      @(negedge clk); flag_clr_i = 1'b0;
   endtask

   task automatic t_reset();
      rst_ni = 1'b0; sense_i = 1'b1; threshold_i = 16'd5; flag_clr_i = 1'b0;
      repeat (3) @(negedge clk);
      check(!detect_o && !event_o && !flag_o, "R1 reset outputs", {detect_o, event_o, flag_o}, 0);
      rst_ni = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_idle();
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (event_o || detect_o || flag_o) seen++;
      end
      check(seen == 0, "R9 idle high quiet", seen, 0);
   endtask

   task automatic t_exact();
      threshold_i = 16'd5;
      pulse(5);
      check(evt_cnt == 1, "R2 exact threshold event count", evt_cnt, 1);
      check(evt_idx == 6, "R2 event edge index", evt_idx, 6);
      check(det_first == 6, "R2 detect rise index", det_first, 6);
      check(flag_o == 1'b1, "R7 flag set after event", int'(flag_o), 1);
      clear_flag();
      check(flag_o == 1'b0, "R7 flag cleared", int'(flag_o), 0);
   endtask

   task automatic t_short();
      threshold_i = 16'd5;
      pulse(4);
      check(evt_cnt == 0, "R3 short pulse event", evt_cnt, 0);
      check(det_cnt == 0, "R3 short pulse detect", det_cnt, 0);
      check(flag_o == 1'b0, "R3 short pulse flag", int'(flag_o), 0);
   endtask

   task automatic t_long();
      threshold_i = 16'd5;
      pulse(100);
      check(evt_cnt == 1, "R4 one event on long pulse", evt_cnt, 1);
      check(det_cnt == 100 + 1 - 5, "R5 detect held length", det_cnt, 96);
      check(det_fall == 102, "R5 detect fall index", det_fall, 102);
      clear_flag();
   endtask

   task automatic t_rearm();
      threshold_i = 16'd5;
      pulse(8);
      check(evt_cnt == 1, "R6 first phase event", evt_cnt, 1);
      pulse(8);
      check(evt_cnt == 1, "R6 rearmed phase event", evt_cnt, 1);
      check(evt_idx == 6, "R6 rearmed event index", evt_idx, 6);
      clear_flag();
   endtask

   task automatic t_flag_hold();
      threshold_i = 16'd3;
      pulse(4);
      repeat (20) @(negedge clk);
      check(flag_o == 1'b1, "R7 flag sticky", int'(flag_o), 1);
      clear_flag();
      check(flag_o == 1'b0, "R7 flag clears", int'(flag_o), 0);
   endtask

   task automatic t_set_wins();
      threshold_i = 16'd5;
      @(negedge clk); flag_clr_i = 1'b1;
      pulse(7);
      check(flag_at_evt == 1, "R8 set wins over clear", flag_at_evt, 1);
      check(flag_after_evt == 0, "R8 clear next cycle", flag_after_evt, 0);
      flag_clr_i = 1'b0;
   endtask

   task automatic t_zero();
      threshold_i = 16'd0;
      pulse(1);
      check(evt_cnt == 1, "R10 zero threshold single sample", evt_cnt, 1);
      check(evt_idx == 2, "R10 zero threshold index", evt_idx, 2);
      clear_flag();
   endtask

   task automatic t_default();
      threshold_i = 16'd1000;
      pulse(999);
      check(evt_cnt == 0, "R3 default threshold minus one", evt_cnt, 0);
      pulse(1000);
      check(evt_idx == 1001, "R2 default threshold index", evt_idx, 1001);
      clear_flag();
   endtask

   initial begin
      t_reset();
      t_idle();
      t_exact();
      t_short();
      t_long();
      t_rearm();
      t_flag_hold();
      t_set_wins();
      t_zero();
      t_default();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule